// File: doc/BRIEF.md
# Dual-Chip-Select Byte SPI Master

This block is an SPI master that software runs through a small register bus. Each command moves exactly one byte, and each byte is either a read or a write. Data never moves in both directions at once. Two identical register groups sit in the address map. Both drive the same serial clock and data lines, and each group owns only its own active-low chip-select pin. Software is expected to use one group at a time.

To run a transfer, software first writes a group's configuration word, which sets the clock prescale, idle polarity, sampling edge, launch edge and bit order. It then writes the control word to start a single-byte read or write. It polls the busy flag in the status word until the flag drops. For a write, the byte comes from the data word. For a read, the result lands in the data word on the same clock edge that busy falls. A separate word at 0xF0 holds a one-bit arbitration enable.

Top module: `spi_dual_cs_master`

## Requirements
- R1: After reset, both chip-selects are high, sck_o and mosi_o are 0, and neither group is busy. The configuration and data words of both groups read 0, and each control word reads 1.
- R2: Group 0 is at 0x00 and group 1 at 0x40. Within a group, status is at +0x00, configuration at +0x10, control at +0x14 and data at +0x20. The configuration word reads back its bits 8, 6, 5, 4 and 2:0, with every other bit 0.
- R3: Status bit 0 (busy) rises in the cycle after the start write. It stays high for exactly 16·2^P system cycles, and only the group that started the transfer reports busy.
- R4: The serial clock takes the value of configuration bit 6 when a transfer starts. Its period is 2^(P+1) system cycles, where P is configuration bits 2:0, and a P above 6 acts as 6. It makes 16 transitions per byte.
- R5: Configuration bit 5 picks the sampling edge (0 = rising, 1 = falling), and bit 4 picks the launch edge (0 = rising, 1 = falling). The first bit is on mosi_o before the first sampling edge, and each later bit is launched on the first launch edge after the previous sample.
- R6: Configuration bit 8 set sends and receives MSB first. Bit 8 clear sends and receives LSB first.
- R7: Control bit 2 starts a write that shifts out data bits 7:0. A write leaves the data word unchanged, whatever miso_i does.
- R8: Control bit 1 starts a read. When busy falls, the received byte is in data bits 7:0 and bits 31:8 read 0.
- R9: Control bit 0 drives that group's chip-select pin directly (1 = high, 0 = low). Group g drives cs_no[g]. Control bits 2:1 always read 0.
- R10: A start request is ignored while either group is busy. If control bits 2 and 1 are both set, the transfer is a write.
- R11: While no transfer runs, sck_o holds the polarity of the last transfer and mosi_o holds its last value, even if a configuration changes.
- R12: Bit 31 of the word at 0xF0 is a read/write enable flag, and all other bits of that word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| sck_o | output | 1 | Shared serial clock |
| mosi_o | output | 1 | Shared serial data out |
| miso_i | input | 1 | Shared serial data in |
| cs_no | output | 2 | Active-low chip-selects, one per group |

## Verification
The assertions on idle hold and chip-select stability assume that nothing but a register write changes the bus state. They also assume that software does not expect both groups to hold busy at once. The bench respects both assumptions. It changes register contents only through single write strobes, and it overlaps transfers only to test that a second start is refused. It moves miso_i only on the negative system-clock edge, after a sampling transition of sck_o it has seen. This keeps the input stable around every sampling edge, which the read-data checks rely on.

// File: rtl/spi_dcs_pkg.sv
package spi_dcs_pkg;
  localparam int unsigned PRE_W = 3;

  typedef struct packed {
    logic             msb_first;
    logic             cpol;
    logic             rx_fall;
    logic             tx_fall;
    logic [PRE_W-1:0] pre;
  } spi_cfg_t;

  localparam logic [5:0] OFF_STAT = 6'h00;
  localparam logic [5:0] OFF_CFG  = 6'h10;
  localparam logic [5:0] OFF_CTL  = 6'h14;
  localparam logic [5:0] OFF_DATA = 6'h20;
  localparam logic [7:0] ADDR_ARB = 8'hF0;
  localparam logic [8:0] CFG_MASK = 9'h177;

  localparam int unsigned CTL_CS  = 0;
  localparam int unsigned CTL_RD  = 1;
  localparam int unsigned CTL_WR  = 2;
endpackage

// File: rtl/spi_dcs_group.sv
module spi_dcs_group
  import spi_dcs_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [5:0]        off_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output spi_cfg_t          cfg_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic              cs_n_o,
  output logic              start_o,
  output logic              start_rd_o,
  output logic [31:0]       rdata_o
);
  logic [8:0]        cfg_q;
  logic [BYTE_W-1:0] data_q;
  logic              cs_q;
  logic              ctl_wr;

  assign ctl_wr = wr_i && (off_i == OFF_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      data_q <= '0;
      cs_q   <= 1'b1;
    end else begin
      if (wr_i && (off_i == OFF_CFG)) cfg_q <= wdata_i[8:0] & CFG_MASK;
      if (ctl_wr) cs_q <= wdata_i[CTL_CS];
      if (ld_i) data_q <= ld_data_i;
      else if (wr_i && (off_i == OFF_DATA)) data_q <= wdata_i[BYTE_W-1:0];
    end
  end

  assign cfg_o = '{msb_first: cfg_q[8], cpol: cfg_q[6], rx_fall: cfg_q[5],
                   tx_fall: cfg_q[4], pre: cfg_q[2:0]};
  assign tx_o       = data_q;
  assign cs_n_o     = cs_q;
  assign start_o    = ctl_wr && (wdata_i[CTL_WR] || wdata_i[CTL_RD]);
  // write wins when both start bits are set
  assign start_rd_o = !wdata_i[CTL_WR];

  always_comb begin
    unique case (off_i)
      OFF_STAT: rdata_o = {31'b0, busy_i};
      OFF_CFG:  rdata_o = {23'b0, cfg_q};
      OFF_CTL:  rdata_o = {31'b0, cs_q};
      OFF_DATA: rdata_o = {{(32-BYTE_W){1'b0}}, data_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_dcs_engine.sv
module spi_dcs_engine
  import spi_dcs_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PRE_MAX = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  spi_cfg_t          cfg_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int unsigned HALF_W = PRE_MAX + 1;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam int unsigned TOG_W  = $clog2(2 * BYTE_W);

  logic              busy_q, sck_q, mosi_q, msb_q, rxf_q, txf_q;
  logic [HALF_W-1:0] half_q, div_q;
  logic [TOG_W-1:0]  tog_q;
  logic [IDX_W-1:0]  tx_idx_q;
  logic [IDX_W:0]    rx_cnt_q, rx_cnt_nxt;
  logic [BYTE_W-1:0] tx_sr_q, rx_q, rx_nxt;
  logic [PRE_W-1:0]  pre_eff;
  logic              tick, rising, rx_edge, tx_edge, last, advance;
  logic [IDX_W-1:0]  rx_pos, tx_nxt_idx, tx_pos;

  function automatic logic [IDX_W-1:0] pos_of(logic [IDX_W-1:0] idx, logic msb);
    return msb ? (IDX_W'(BYTE_W - 1) - idx) : idx;
  endfunction

  assign pre_eff    = (cfg_i.pre > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : cfg_i.pre;
  assign tick       = busy_q && (div_q == half_q - 1'b1);
  assign rising     = !sck_q;
  assign rx_edge    = tick && (rising ^ rxf_q);
  assign tx_edge    = tick && (rising ^ txf_q);
  assign last       = tick && (tog_q == '1);
  assign rx_cnt_nxt = rx_cnt_q + {{IDX_W{1'b0}}, rx_edge};
  assign advance    = tx_edge && (rx_cnt_nxt > {1'b0, tx_idx_q}) && (tx_idx_q != '1);
  assign rx_pos     = pos_of(rx_cnt_q[IDX_W-1:0], msb_q);
  assign tx_nxt_idx = tx_idx_q + 1'b1;
  assign tx_pos     = pos_of(tx_nxt_idx, msb_q);

  always_comb begin
    rx_nxt = rx_q;
    if (rx_edge) rx_nxt[rx_pos] = miso_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      msb_q    <= 1'b0;
      rxf_q    <= 1'b0;
      txf_q    <= 1'b0;
      half_q   <= HALF_W'(1);
      div_q    <= '0;
      tog_q    <= '0;
      tx_idx_q <= '0;
      rx_cnt_q <= '0;
      tx_sr_q  <= '0;
      rx_q     <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        sck_q    <= cfg_i.cpol;
        msb_q    <= cfg_i.msb_first;
        rxf_q    <= cfg_i.rx_fall;
        txf_q    <= cfg_i.tx_fall;
        half_q   <= HALF_W'(1) << pre_eff;
        div_q    <= '0;
        tog_q    <= '0;
        tx_idx_q <= '0;
        rx_cnt_q <= '0;
        tx_sr_q  <= tx_i;
        rx_q     <= '0;
        mosi_q   <= tx_i[pos_of('0, cfg_i.msb_first)];
      end
    end else if (tick) begin
      div_q    <= '0;
      sck_q    <= !sck_q;
      tog_q    <= tog_q + 1'b1;
      rx_cnt_q <= rx_cnt_nxt;
      rx_q     <= rx_nxt;
      if (last) busy_q <= 1'b0;
      if (advance) begin
        tx_idx_q <= tx_nxt_idx;
        mosi_q   <= tx_sr_q[tx_pos];
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = last;
  assign rx_o   = rx_nxt;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/spi_dual_cs_master.sv
module spi_dual_cs_master
  import spi_dcs_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PRE_MAX = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [1:0]  cs_no
);
  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned GRP_W   = $clog2(NUM_GRP);

  spi_cfg_t          cfg_g   [NUM_GRP];
  logic [BYTE_W-1:0] tx_g    [NUM_GRP];
  logic [31:0]       rdata_g [NUM_GRP];
  logic [NUM_GRP-1:0] start_req, start_rd, grp_busy, grp_ld;
  logic [GRP_W-1:0]  sel, owner_q;
  logic              op_rd_q, arb_q, start_ok;
  logic              eng_busy, eng_done;
  logic [BYTE_W-1:0] eng_rx;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit         = (addr_i[7:6] == 2'(g));
    assign grp_busy[g] = eng_busy && (owner_q == GRP_W'(g));
    assign grp_ld[g]   = eng_done && op_rd_q && (owner_q == GRP_W'(g));

    spi_dcs_group #(.BYTE_W(BYTE_W)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (we_i && hit),
      .off_i      (addr_i[5:0]),
      .wdata_i    (wdata_i),
      .busy_i     (grp_busy[g]),
      .ld_i       (grp_ld[g]),
      .ld_data_i  (eng_rx),
      .cfg_o      (cfg_g[g]),
      .tx_o       (tx_g[g]),
      .cs_n_o     (cs_no[g]),
      .start_o    (start_req[g]),
      .start_rd_o (start_rd[g]),
      .rdata_o    (rdata_g[g])
    );
  end

  always_comb begin
    sel = '0;
    for (int g = 0; g < NUM_GRP; g++) if (start_req[g]) sel = GRP_W'(g);
  end

  assign start_ok = (|start_req) && !eng_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      op_rd_q <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      if (start_ok) begin
        owner_q <= sel;
        op_rd_q <= start_rd[sel];
      end
      if (we_i && (addr_i == ADDR_ARB)) arb_q <= wdata_i[31];
    end
  end

  spi_dcs_engine #(.BYTE_W(BYTE_W), .PRE_MAX(PRE_MAX)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .cfg_i   (cfg_g[sel]),
    .tx_i    (tx_g[sel]),
    .miso_i  (miso_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );

  always_comb begin
    if (addr_i == ADDR_ARB)  rdata_o = {arb_q, 31'b0};
    else if (!addr_i[7])     rdata_o = rdata_g[addr_i[6]];
    else                     rdata_o = '0;
  end
endmodule

// File: rtl/spi_dcs_checker.sv
module spi_dcs_checker #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PRE_MAX = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       start_ok_i,
  input logic       busy_i,
  input logic [1:0] grp_busy_i,
  input logic       sck_i,
  input logic       mosi_i,
  input logic [1:0] cs_n_i
);
  localparam int unsigned MIN_LEN = 2 * BYTE_W;
  localparam int unsigned MAX_LEN = MIN_LEN << PRE_MAX;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN) + 2;

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else         len_q <= busy_i ? len_q + 1'b1 : '0;
  end

  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok_i |=> busy_i); // R3
  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_busy_i)); // R3
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($countones(len_q) == 1 && len_q >= LEN_W'(MIN_LEN)
                       && len_q <= LEN_W'(MAX_LEN))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !we_i) |=> ($stable(sck_i) && $stable(mosi_i))); // R11
  AST_CS_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cs_n_i)); // R9
endmodule

bind spi_dual_cs_master spi_dcs_checker #(.BYTE_W(BYTE_W), .PRE_MAX(PRE_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .start_ok_i (start_ok),
  .busy_i     (eng_busy),
  .grp_busy_i (grp_busy),
  .sck_i      (sck_o),
  .mosi_i     (mosi_o),
  .cs_n_i     (cs_no)
);

// File: tb/test_spi_dual_cs_master.sv
module test_spi_dual_cs_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, miso = 1'b0;
  logic [1:0]  cs_n;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = !clk;

  spi_dual_cs_master i_spi_dual_cs_master (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_idle(input logic [7:0] base);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); rd(base, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic bit_of(input logic [7:0] b, input int n, input logic msb);
    return msb ? b[7-n] : b[n];
  endfunction

  task automatic xfer(input int g, input logic [8:0] cfg, input logic is_rd,
                      input logic [7:0] tx, input logic [7:0] sb,
                      output logic [7:0] cap, output int bcyc, output int togs,
                      output logic first_sck);
    logic [7:0]  base;
    logic [31:0] v;
    logic        prev_sck, prev_mosi, msb, rxf;
    int          nsamp;
    base = 8'(g * 64);
    msb = cfg[8]; rxf = cfg[5];
    cap = '0; nsamp = 0; togs = 0;
    wr(base + 8'h20, {24'b0, tx});
    wr(base + 8'h10, {23'b0, cfg});
    miso = bit_of(sb, 0, msb);
    @(negedge clk); we = 1'b1; addr = base + 8'h14; wdata = is_rd ? 32'h2 : 32'h4;
    @(negedge clk); we = 1'b0; rd(base, v);
    bcyc = v[0] ? 1 : 0;
    first_sck = sck; prev_sck = sck; prev_mosi = mosi;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      #1;
      if (sck !== prev_sck) begin
        togs++;
        if (sck == !rxf && nsamp < 8) begin
          if (msb) cap[7-nsamp] = prev_mosi; else cap[nsamp] = prev_mosi;
          nsamp++;
          if (nsamp < 8) miso = bit_of(sb, nsamp, msb);
        end
      end
      prev_sck = sck; prev_mosi = mosi;
      if (rdata[0]) bcyc++;
      else break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  cap, tx, sb;
    logic [8:0]  cfg;
    logic        fs, m_hold;
    int          bc, tg;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs", {30'b0, cs_n}, 32'h3);
    chk("R1 sck/mosi", {30'b0, sck, mosi}, 32'h0);
    for (int g = 0; g < 2; g++) begin
      rd(8'(g*64), v);        chk("R1 stat", v, 32'h0);
      rd(8'(g*64 + 16), v);   chk("R1 cfg", v, 32'h0);
      rd(8'(g*64 + 20), v);   chk("R1 ctl", v, 32'h1);
      rd(8'(g*64 + 32), v);   chk("R1 data", v, 32'h0);
    end
    // R2 map and cfg readback
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R2 cfg mask", v, 32'h177);
    rd(8'h50, v); chk("R2 group1 cfg untouched", v, 32'h0);
    wr(8'h60, 32'h5A); rd(8'h60, v); chk("R2 group1 data", v, 32'h5A);
    rd(8'h20, v); chk("R2 group0 data", v, 32'h0);
    // R12 arbitration word
    wr(8'hF0, 32'hFFFF_FFFF); rd(8'hF0, v); chk("R12 set", v, 32'h8000_0000);
    wr(8'hF0, 32'h7FFF_FFFF); rd(8'hF0, v); chk("R12 clear", v, 32'h0);
    // R9 chip-selects
    wr(8'h14, 32'h0); chk("R9 g0 low", {30'b0, cs_n}, 32'h2);
    wr(8'h54, 32'h6 & 32'h0); chk("R9 both low", {30'b0, cs_n}, 32'h0);
    wr(8'h14, 32'h1); chk("R9 g0 high", {30'b0, cs_n}, 32'h1);
    rd(8'h54, v); chk("R9 ctl readback", v, 32'h0);
    wr(8'h54, 32'h1);
    // sweep: group, mode bits, order, prescale
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 16; m++) begin
        for (int p = 0; p < 2; p++) begin
          cfg = {m[3], 1'b0, m[2], m[1], m[0], 1'b0, 3'(p)};
          tx = 8'(8'hA5 ^ (m * 17) ^ (p * 3) ^ (g * 8'h5A));
          sb = 8'(~tx ^ 8'h3C);
          xfer(g, cfg, 1'b0, tx, sb, cap, bc, tg, fs);
          chk("R3 busy length", bc, 32'(16 << p));
          chk("R4 transitions", tg, 16);
          chk("R4 start polarity", {31'b0, fs}, {31'b0, cfg[6]});
          if (cfg[8]) chk("R5 write bits msb-first", {24'b0, cap}, {24'b0, tx});
          else        chk("R6 write bits lsb-first", {24'b0, cap}, {24'b0, tx});
          rd(8'(g*64 + 32), v); chk("R7 data kept", v, {24'b0, tx});
          rd(8'(g*64 + 16), v); chk("R2 cfg readback", v, {23'b0, cfg});
          rd(8'((1-g)*64), v);  chk("R3 other group idle", v, 32'h0);
          xfer(g, cfg, 1'b1, tx, sb, cap, bc, tg, fs);
          chk("R3 busy length rd", bc, 32'(16 << p));
          @(negedge clk);
          rd(8'(g*64 + 32), v); chk("R8 read data", v, {24'b0, sb});
          m_hold = mosi;
          wr(8'(g*64 + 16), {23'b0, cfg ^ 9'h040});
          repeat (4) @(negedge clk);
          chk("R11 sck idle", {31'b0, sck}, {31'b0, cfg[6]});
          chk("R11 mosi hold", {31'b0, mosi}, {31'b0, m_hold});
        end
      end
    end
    // R4 prescale above 6 clamps to 6
    xfer(0, 9'h107, 1'b0, 8'hC3, 8'h00, cap, bc, tg, fs);
    chk("R4 clamp length", bc, 32'(16 << 6));
    chk("R4 clamp data", {24'b0, cap}, 32'hC3);
    // R10 start ignored while busy; both start bits means write
    wr(8'h10, 32'h101); wr(8'h20, 32'h3C); wr(8'h50, 32'h001);
    wr(8'h14, 32'h4);
    wr(8'h54, 32'h6);
    rd(8'h40, v); chk("R10 g1 refused", v, 32'h0);
    wr(8'h14, 32'h2);
    wait_idle(8'h00);
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R10 g0 no restart", v, 32'h0);
    rd(8'h40, v); chk("R10 g1 still idle", v, 32'h0);
    rd(8'h20, v); chk("R10 restart as read ignored", v, 32'h3C);
    miso = 1'b1;
    wr(8'h20, 32'h81); wr(8'h14, 32'h6);
    rd(8'h00, v); chk("R10 both bits start", v, 32'h1);
    wait_idle(8'h00);
    rd(8'h20, v); chk("R10 both bits is write", v, 32'h81);
    chk("R7 miso ignored", v, 32'h81);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule